// File: doc/BRIEF.md
# Extended Page Override Sequencer

This block runs beside a processor's decode and address path and carries out the effect of a prefix instruction that redirects data addressing for a short run of following instructions. When the prefix decodes, the block latches a 10-bit page number and loads a run counter. The page comes either from the low bits of a general register or from an immediate field. The counter is loaded from a 2-bit length field.

While the counter is non-zero, the block does three things. Every long or indirect data access takes its upper ten physical address bits from the latched page instead of the page the data page register supplies. Register-mode and bit-mode accesses to special function registers are steered to the extended register space. Ordinary interrupts, peripheral event transfers and class A traps are held off.

Each retired instruction after the prefix lowers the count by one. A class B trap clears the run at once, however many instructions remain. The block does not touch any condition flags.

Top module: `epo_seq`

## Requirements
- R1: After a synchronous active-low reset, and while no run is active, `sfr_ext`, `irq_lock` and `page_ovr` are 0, and `phys_addr` equals {`dpp_page`, `addr_offset`}.
- R2: The length field `pfx_len_code` holds the run length minus one. Codes 0 to 3 keep the run active for exactly 1 to 4 retire pulses, and idle cycles without a retire do not shorten it.
- R3: While a run is active and `addr_long` is 1, `phys_addr[23:14]` equals the latched page. From the cycle after the last covered retire, it equals `dpp_page` again.
- R4: `phys_addr[13:0]` always equals `addr_offset`, whether or not a run is active.
- R5: When `addr_long` is 0, `phys_addr[23:14]` equals `dpp_page` even during a run, and `page_ovr` is 0.
- R6: `sfr_ext` is 1 exactly while a run is active.
- R7: `irq_lock` is 1 exactly while a run is active.
- R8: With `pfx_imm_form`=1 the latched page is `pfx_imm_page`. With `pfx_imm_form`=0 it is `pfx_reg_val[9:0]` as sampled on the prefix edge, and `pfx_reg_val[15:10]` has no effect.
- R9: `trap_b` high on a clock edge makes the run inactive from that edge on, whatever count remains. It also overrides a prefix presented on the same edge.
- R10: A retire pulse on the same edge as the prefix is not counted. A prefix decoded during a run reloads both the page and the count.
- R11: Retire pulses while no run is active leave the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_valid | input | 1 | Prefix instruction executes this cycle |
| pfx_imm_form | input | 1 | 1: page from immediate, 0: page from register |
| pfx_len_code | input | 2 | Run length minus one |
| pfx_reg_val | input | 16 | Register operand value |
| pfx_imm_page | input | 10 | Immediate page field |
| instr_retire | input | 1 | One instruction completed |
| trap_b | input | 1 | Class B trap condition |
| addr_long | input | 1 | Current data access is long or indirect |
| dpp_page | input | 10 | Page from the selected data page register |
| addr_offset | input | 14 | Page offset of the current access |
| phys_addr | output | 24 | Resulting physical data address |
| page_ovr | output | 1 | Override applied to this access |
| ovr_page | output | 10 | Latched override page |
| sfr_ext | output | 1 | Special function register accesses use extended space |
| irq_lock | output | 1 | Interrupts, event transfers and class A traps held off |

## Verification
A wrong count appears at the ports as a run that ends one retire too early or too late. This shows on `sfr_ext`, `irq_lock` and the upper address bits in the cycle after the expected last retire. A wrong latched page is visible on the first long access after the prefix edge, and a missed trap clear is visible in the cycle after the trap. Because every output follows the counter and page registers through combinational logic only, an internal fault reaches the ports no later than one clock after it arises.

// File: rtl/epo_pkg.sv
// Shared sizes for the extended page override sequencer.
// Assumes a 24-bit data address split into a 10-bit page and 14-bit offset.
package epo_pkg;
    localparam int PAGE_W = 10;
    localparam int OFF_W  = 14;
    localparam int LEN_W  = 2;
    localparam int REG_W  = 16;
    localparam int CNT_W  = LEN_W + 1;
    localparam int ADDR_W = PAGE_W + OFF_W;
endpackage

// File: rtl/epo_load_sel.sv
// Chooses the page source and the run length for a prefix decode.
// Assumes the register operand is already read; only its low PAGE_W bits form a page.
module epo_load_sel #(
    parameter int PAGE_W = epo_pkg::PAGE_W,
    parameter int REG_W  = epo_pkg::REG_W,
    parameter int LEN_W  = epo_pkg::LEN_W,
    parameter int CNT_W  = epo_pkg::CNT_W
) (
    input  logic              imm_form,
    input  logic [REG_W-1:0]  reg_val,
    input  logic [PAGE_W-1:0] imm_page,
    input  logic [LEN_W-1:0]  len_code,
    output logic [PAGE_W-1:0] sel_page,
    output logic [CNT_W-1:0]  run_len
);
    logic unused_reg_hi;

    // Upper register bits carry no page information.
    assign unused_reg_hi = ^reg_val[REG_W-1:PAGE_W];

    // Page source and length decode (code holds length minus one).
    always_comb begin
        sel_page = imm_form ? imm_page : reg_val[PAGE_W-1:0];
        run_len  = CNT_W'(len_code) + CNT_W'(1);
    end
endmodule

// File: rtl/epo_run_ctr.sv
// Counts the instructions still covered by the override.
// Assumes retire pulses last one cycle; trap beats load, load beats retire.
module epo_run_ctr #(
    parameter int CNT_W = epo_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] run_len,
    input  logic             retire,
    input  logic             trap,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    logic [CNT_W-1:0] cnt_q;

    // Counter update with trap, load, retire priority.
    always_ff @(posedge clk) begin
        if (!rst_n || trap)
            cnt_q <= '0;
        else if (load)
            cnt_q <= run_len;
        else if (retire && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt    = cnt_q;
    assign active = (cnt_q != '0);

    assert_trap_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (cnt_q == '0));
    assert_retire_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && !load && retire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && !load && (!retire || cnt_q == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/epo_page_reg.sv
// Holds the override page captured on a prefix edge.
// Assumes load is already qualified against the trap condition.
module epo_page_reg #(
    parameter int PAGE_W = epo_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] sel_page,
    output logic [PAGE_W-1:0] page_q
);
    // Capture the page when a prefix is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (load)
            page_q <= sel_page;
    end
endmodule

// File: rtl/epo_addr_mux.sv
// Builds the physical data address from page and offset.
// Assumes addr_long marks long or indirect accesses only.
module epo_addr_mux #(
    parameter int PAGE_W = epo_pkg::PAGE_W,
    parameter int OFF_W  = epo_pkg::OFF_W,
    parameter int ADDR_W = epo_pkg::ADDR_W
) (
    input  logic              active,
    input  logic              addr_long,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [PAGE_W-1:0] dpp_page,
    input  logic [OFF_W-1:0]  addr_offset,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              hit
);
    // Replace the page bits only for covered long or indirect accesses.
    always_comb begin
        hit       = active && addr_long;
        phys_addr = {(hit ? page_q : dpp_page), addr_offset};
    end
endmodule

// File: rtl/epo_seq.sv
// Top of the extended page override sequencer.
// Assumes pfx_valid is a one-cycle decode strobe and trap_b is sampled per clock.
module epo_seq #(
    parameter int PAGE_W = epo_pkg::PAGE_W,
    parameter int OFF_W  = epo_pkg::OFF_W,
    parameter int LEN_W  = epo_pkg::LEN_W,
    parameter int REG_W  = epo_pkg::REG_W,
    localparam int CNT_W  = LEN_W + 1,
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_valid,
    input  logic              pfx_imm_form,
    input  logic [LEN_W-1:0]  pfx_len_code,
    input  logic [REG_W-1:0]  pfx_reg_val,
    input  logic [PAGE_W-1:0] pfx_imm_page,
    input  logic              instr_retire,
    input  logic              trap_b,
    input  logic              addr_long,
    input  logic [PAGE_W-1:0] dpp_page,
    input  logic [OFF_W-1:0]  addr_offset,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              page_ovr,
    output logic [PAGE_W-1:0] ovr_page,
    output logic              sfr_ext,
    output logic              irq_lock
);
    logic [PAGE_W-1:0] sel_page;
    logic [CNT_W-1:0]  run_len;
    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic              accept;

    // A prefix is taken only when no class B trap is present.
    assign accept = pfx_valid && !trap_b;

    epo_load_sel #(.PAGE_W(PAGE_W), .REG_W(REG_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_sel (
        .imm_form (pfx_imm_form),
        .reg_val  (pfx_reg_val),
        .imm_page (pfx_imm_page),
        .len_code (pfx_len_code),
        .sel_page (sel_page),
        .run_len  (run_len)
    );

    epo_run_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pfx_valid),
        .run_len (run_len),
        .retire  (instr_retire),
        .trap    (trap_b),
        .cnt     (cnt),
        .active  (active)
    );

    epo_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .sel_page (sel_page),
        .page_q   (ovr_page)
    );

    epo_addr_mux #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_mux (
        .active      (active),
        .addr_long   (addr_long),
        .page_q      (ovr_page),
        .dpp_page    (dpp_page),
        .addr_offset (addr_offset),
        .phys_addr   (phys_addr),
        .hit         (page_ovr)
    );

    // Register-space steering and interrupt hold follow the run state.
    assign sfr_ext  = active;
    assign irq_lock = active;

    assert_load_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cnt == CNT_W'($past(pfx_len_code)) + CNT_W'(1)));
    assert_reg_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pfx_imm_form) |=> (ovr_page == $past(pfx_reg_val[PAGE_W-1:0])));
    assert_imm_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pfx_imm_form) |=> (ovr_page == $past(pfx_imm_page)));
    assert_short_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_long |-> (phys_addr[ADDR_W-1:OFF_W] == dpp_page && !page_ovr));
    assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == addr_offset);
endmodule

// File: tb/epo_seq_tb.sv
`timescale 1ns/1ps
module epo_seq_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        pfx_valid = 0, pfx_imm_form = 0;
    logic [1:0]  pfx_len_code = '0;
    logic [15:0] pfx_reg_val = '0;
    logic [9:0]  pfx_imm_page = '0;
    logic        instr_retire = 0, trap_b = 0, addr_long = 0;
    logic [9:0]  dpp_page = 10'h155;
    logic [13:0] addr_offset = 14'h1234;
    logic [23:0] phys_addr;
    logic        page_ovr, sfr_ext, irq_lock;
    logic [9:0]  ovr_page;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    epo_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_imm_form(pfx_imm_form),
        .pfx_len_code(pfx_len_code), .pfx_reg_val(pfx_reg_val), .pfx_imm_page(pfx_imm_page),
        .instr_retire(instr_retire), .trap_b(trap_b), .addr_long(addr_long),
        .dpp_page(dpp_page), .addr_offset(addr_offset), .phys_addr(phys_addr),
        .page_ovr(page_ovr), .ovr_page(ovr_page), .sfr_ext(sfr_ext), .irq_lock(irq_lock)
    );

    // Vector: {imm_form, len_code, reg_val, imm_page}
    localparam logic [28:0] VEC [8] = '{
        {1'b0, 2'd0, 16'hFC05, 10'h2AA},
        {1'b1, 2'd1, 16'h0000, 10'h3FF},
        {1'b0, 2'd2, 16'h03C3, 10'h001},
        {1'b1, 2'd3, 16'hFFFF, 10'h0F0},
        {1'b0, 2'd3, 16'hA5A5, 10'h000},
        {1'b1, 2'd0, 16'h1234, 10'h200},
        {1'b0, 2'd1, 16'h7FFF, 10'h155},
        {1'b1, 2'd2, 16'h0400, 10'h07E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_checks(input string req);
        addr_long = 1; #1;
        check(req, {31'd0, sfr_ext}, 32'd0);
        check(req, {31'd0, irq_lock}, 32'd0);
        check(req, {8'd0, phys_addr}, {8'd0, dpp_page, addr_offset});
    endtask

    task automatic prefix(input bit f, input logic [1:0] c, input logic [15:0] rv,
                          input logic [9:0] ip, input bit ret);
        pfx_valid = 1; pfx_imm_form = f; pfx_len_code = c;
        pfx_reg_val = rv; pfx_imm_page = ip; instr_retire = ret;
        tick();
        pfx_valid = 0; instr_retire = 0; pfx_reg_val = 16'h0000; pfx_imm_page = 10'h0;
    endtask

    task automatic retire_one();
        instr_retire = 1;
        tick();
        instr_retire = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        idle_checks("R1 reset");

        // Table walk: prefix edge also carries a retire that must not count (R10).
        for (int v = 0; v < 8; v++) begin
            logic        f;
            logic [1:0]  c;
            logic [15:0] rv;
            logic [9:0]  ip, pg;
            int          n;
            {f, c, rv, ip} = VEC[v];
            pg = f ? ip : rv[9:0];
            n  = int'(c) + 1;
            addr_offset = 14'(16'h0101 * (v + 1));
            prefix(f, c, rv, ip, 1'b1);
            addr_long = 1; #1;
            check("R8 page", {22'd0, phys_addr[23:14]}, {22'd0, pg});
            check("R4 offset", {18'd0, phys_addr[13:0]}, {18'd0, addr_offset});
            check("R6 sfr_ext", {31'd0, sfr_ext}, 32'd1);
            check("R7 irq_lock", {31'd0, irq_lock}, 32'd1);
            addr_long = 0; #1;
            check("R5 short", {21'd0, page_ovr, phys_addr[23:14]}, {22'd0, dpp_page});
            for (int k = 1; k <= n; k++) begin
                retire_one();
                addr_long = 1; #1;
                check("R2 length", {31'd0, sfr_ext}, {31'd0, (k < n)});
                check("R3 page", {22'd0, phys_addr[23:14]}, {22'd0, (k < n) ? pg : dpp_page});
            end
        end

        // R11: retires while idle do nothing.
        repeat (3) retire_one();
        idle_checks("R11 idle retire");

        // R2: idle cycles without retire hold the run.
        prefix(1'b1, 2'd0, 16'h0, 10'h321, 1'b0);
        repeat (5) tick();
        addr_long = 1; #1;
        check("R2 hold", {31'd0, sfr_ext}, 32'd1);
        retire_one();
        idle_checks("R2 end");

        // R9: trap mid-run with count remaining.
        prefix(1'b1, 2'd3, 16'h0, 10'h0AB, 1'b0);
        retire_one();
        trap_b = 1; tick(); trap_b = 0;
        idle_checks("R9 trap");

        // R9: trap on the same edge as a prefix.
        trap_b = 1;
        prefix(1'b1, 2'd3, 16'h0, 10'h0CD, 1'b0);
        trap_b = 0;
        idle_checks("R9 trap vs prefix");

        // R10: reload during a run.
        prefix(1'b0, 2'd3, 16'h00AA, 10'h0, 1'b0);
        repeat (3) retire_one();
        prefix(1'b1, 2'd1, 16'h0, 10'h3C3, 1'b0);
        addr_long = 1; #1;
        check("R10 reload page", {22'd0, phys_addr[23:14]}, 32'h3C3);
        retire_one(); #1;
        check("R10 reload count", {31'd0, irq_lock}, 32'd1);
        retire_one();
        idle_checks("R10 reload end");

        // R1: reset during a run.
        prefix(1'b1, 2'd3, 16'h0, 10'h111, 1'b0);
        rst_n = 0; tick(); rst_n = 1;
        idle_checks("R1 reset mid-run");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule